// File: doc/BRIEF.md
# LIN Slave Transceiver Mode Controller

This block is the digital control unit of a LIN slave transceiver that also contains a supply regulator. It tracks five operating modes: Unpowered, Fail-safe, Normal, Silent and Sleep. From these modes it drives the enables for the transmitter, the receive path, the regulator and the full bus termination. It also drives the open-drain reset level and a forced-low override on the receive data pin. Analog detectors report to it as synchronous flags: supply present, supply low, regulator undervoltage, bus wake request and pre-wake. The host's enable and transmit-data pins arrive asynchronously and pass through two-flop synchronizers.

All timing is counted in periods of a microsecond tick input. The reset hold after power-up and the undervoltage debounce are parameters given in ticks. The host leaves Normal mode by pulling the enable pin low. The transmit-data level sampled at the first tick after that falling edge then selects Silent (high) or Sleep (low). A bus wake from either low-power mode is reported by holding the receive data pin low.

Top module: `lin_mode_ctrl`

## Requirements
- R1: Out of reset and while unpowered, the pattern {reg_en, tx_en, rx_en, nres_o, term_full, rxd_force_low} is 000000. When sup_ok rises with sup_low clear, the block enters Fail-safe: reg_en=1, term_full=1, tx_en=rx_en=0 and nres_o=0.
- R2: On entry to Fail-safe from Unpowered or Sleep, or after an undervoltage trip, nres_o stays low until RST_HOLD ticks have been counted with vcc_uv low. The count restarts while vcc_uv is high. en_pin has no effect during the hold.
- R3: In Fail-safe with the hold over, en_pin high moves the block to Normal, where tx_en=1, rx_en=1 and nres_o=1.
- R4: In Normal, a falling edge on the synchronized en_pin, with txd_pin high at the first tick after the edge, selects Silent: reg_en=1, nres_o=1, tx_en=rx_en=0, term_full=0, rxd_force_low=0.
- R5: In Normal, an en_pin falling edge with txd_pin low at that first tick selects Sleep: reg_en=0, nres_o=0, rxd_force_low=1, term_full=0. A txd_pin fall one clock after en_pin still selects Sleep.
- R6: In Silent or Sleep, term_full is 0 until prewake is seen. It then stays 1 for the rest of that stay.
- R7: In Silent, bus_wake moves the block to Fail-safe with rxd_force_low=1 and nres_o kept high. en_pin high in Silent returns directly to Normal. Entering Normal clears rxd_force_low.
- R8: In Sleep, bus_wake moves the block to Fail-safe with reg_en=1, rxd_force_low=1 and the reset hold of R2 applied.
- R9: In Normal or Silent, vcc_uv high across UV_DEB ticks forces Fail-safe with nres_o low. A shorter pulse changes nothing.
- R10: sup_low high or sup_ok low returns the block to Unpowered (pattern 000000) at the next clock from any mode. Power returning always lands in Fail-safe with the hold of R2.
- R11: In Sleep, en_pin high moves the block to Fail-safe with the reset hold. Normal follows once the hold ends if en_pin is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| sup_ok | input | 1 | Battery supply above the power-on threshold |
| sup_low | input | 1 | Battery supply below the brown-out level |
| vcc_uv | input | 1 | Regulator output below its undervoltage threshold |
| bus_wake | input | 1 | Filtered remote wake request from the bus |
| prewake | input | 1 | Bus level below the pre-wake detection level |
| en_pin | input | 1 | Host enable pin, asynchronous |
| txd_pin | input | 1 | Host transmit-data pin, asynchronous |
| reg_en | output | 1 | Regulator enable |
| tx_en | output | 1 | Transmit path enable |
| rx_en | output | 1 | Receive path enable |
| nres_o | output | 1 | Reset level to the host, low while asserted |
| term_full | output | 1 | Full slave termination enable (weak pull-up when low) |
| rxd_force_low | output | 1 | Forces the receive data pin low |

## Verification
The supply, wake and prewake flags act on the first clock edge, so their results are sampled one clock after the stimulus. A change on en_pin needs two synchronizer clocks plus one edge-detect clock. A Silent or Sleep choice also waits for the next tick, so mode-select checks sample at least twelve clocks after the edge; return to Normal is checked six clocks after en_pin rises. The reset hold and the debounce are checked on both sides of their limits. One sample lands a few ticks before the count can expire and still expects the reset asserted. The next lands a few ticks after it and expects the new mode, which keeps the one-tick phase uncertainty away from every sample.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

  typedef enum logic [2:0] {
    M_UNPWR    = 3'd0,
    M_FAILSAFE = 3'd1,
    M_NORMAL   = 3'd2,
    M_SILENT   = 3'd3,
    M_SLEEP    = 3'd4
  } lin_mode_e;

  // Regulator is running in these modes.
  function automatic logic mode_reg_on(lin_mode_e m);
    return (m == M_FAILSAFE) || (m == M_NORMAL) || (m == M_SILENT);
  endfunction

  // Modes in which only the weak pull-up terminates the bus.
  function automatic logic mode_low_power(lin_mode_e m);
    return (m == M_SILENT) || (m == M_SLEEP);
  endfunction

  // Counter width able to hold the value lim.
  function automatic int unsigned cnt_width(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/lin_sync2.sv
module lin_sync2 #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stable;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta   <= RST_VAL[i];
        stable <= RST_VAL[i];
      end else begin
        meta   <= d[i];
        stable <= meta;
      end
    end
    assign q[i] = stable;
  end
endmodule

// File: rtl/lin_tick_cnt.sv
module lin_tick_cnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);
  import lin_mode_pkg::*;
  localparam int unsigned CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] FULL = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr)                  cnt <= '0;
    else if (run && cnt != FULL)   cnt <= cnt + 1'b1;
  end

  // Single pulse on the run cycle that reaches the limit; saturates afterwards.
  assign done = run && !clr && (cnt == LAST);
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    sup_ok,
  input  logic                    sup_low,
  input  logic                    en_s,
  input  logic                    en_fall,
  input  logic                    txd_s,
  input  logic                    uv_trip,
  input  logic                    hold_done,
  input  logic                    bus_wake,
  input  logic                    prewake,
  output lin_mode_pkg::lin_mode_e mode,
  output logic                    hold_act,
  output logic                    hold_set,
  output logic                    wake_flag,
  output logic                    pw_seen,
  output logic                    sel_pend
);
  import lin_mode_pkg::*;

  lin_mode_e mode_n;
  logic      wake_set;

  always_comb begin
    mode_n   = mode;
    hold_set = 1'b0;
    wake_set = 1'b0;
    unique case (mode)
      M_UNPWR: begin
        if (sup_ok && !sup_low) begin
          mode_n   = M_FAILSAFE;
          hold_set = 1'b1;
        end
      end
      M_FAILSAFE: begin
        if (uv_trip)                hold_set = 1'b1;
        else if (!hold_act && en_s) mode_n   = M_NORMAL;
      end
      M_NORMAL: begin
        if (uv_trip) begin
          mode_n   = M_FAILSAFE;
          hold_set = 1'b1;
        end else if (sel_pend && tick && !en_s) begin
          mode_n = txd_s ? M_SILENT : M_SLEEP;
        end
      end
      M_SILENT: begin
        if (uv_trip) begin
          mode_n   = M_FAILSAFE;
          hold_set = 1'b1;
        end else if (bus_wake) begin
          mode_n   = M_FAILSAFE;
          wake_set = 1'b1;
        end else if (en_s) begin
          mode_n = M_NORMAL;
        end
      end
      M_SLEEP: begin
        if (bus_wake) begin
          mode_n   = M_FAILSAFE;
          wake_set = 1'b1;
          hold_set = 1'b1;
        end else if (en_s) begin
          mode_n   = M_FAILSAFE;
          hold_set = 1'b1;
        end
      end
      default: mode_n = M_UNPWR;
    endcase
    if (sup_low || !sup_ok) begin
      mode_n   = M_UNPWR;
      hold_set = 1'b0;
      wake_set = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_UNPWR;
      hold_act  <= 1'b1;
      wake_flag <= 1'b0;
      pw_seen   <= 1'b0;
      sel_pend  <= 1'b0;
    end else begin
      mode <= mode_n;

      if (hold_set)                hold_act <= 1'b1;
      else if (mode_n == M_UNPWR)  hold_act <= 1'b1;
      else if (hold_done)          hold_act <= 1'b0;

      if (wake_set)                   wake_flag <= 1'b1;
      else if (mode_n != M_FAILSAFE)  wake_flag <= 1'b0;

      if (!mode_low_power(mode_n) || !mode_low_power(mode)) pw_seen <= 1'b0;
      else if (prewake)                                     pw_seen <= 1'b1;

      if (mode != M_NORMAL || mode_n != M_NORMAL) sel_pend <= 1'b0;
      else if (sel_pend && tick)                  sel_pend <= 1'b0;
      else if (en_fall)                           sel_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl #(
  parameter int unsigned RST_HOLD = 4000,
  parameter int unsigned UV_DEB   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic sup_ok,
  input  logic sup_low,
  input  logic vcc_uv,
  input  logic bus_wake,
  input  logic prewake,
  input  logic en_pin,
  input  logic txd_pin,
  output logic reg_en,
  output logic tx_en,
  output logic rx_en,
  output logic nres_o,
  output logic term_full,
  output logic rxd_force_low
);
  import lin_mode_pkg::*;

  localparam logic [1:0] PIN_RST = 2'b10; // txd idles high, en idles low

  logic [1:0] pins_s;
  logic       en_s, txd_s, en_d;
  logic       en_fall, uv_trip, hold_done, hold_set;
  logic       hold_act, wake_flag, pw_seen, sel_pend;
  lin_mode_e  mode;

  lin_sync2 #(.W(2), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({txd_pin, en_pin}), .q(pins_s)
  );
  assign en_s  = pins_s[0];
  assign txd_s = pins_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_d <= 1'b0;
    else        en_d <= en_s;
  end
  assign en_fall = en_d && !en_s;

  // Undervoltage debounce, active only while the regulator runs.
  lin_tick_cnt #(.LIMIT(UV_DEB)) u_deb (
    .clk(clk), .rst_n(rst_n),
    .clr(!vcc_uv || !mode_reg_on(mode)),
    .run(tick_us),
    .done(uv_trip)
  );

  // Reset hold, counting only good-supply ticks.
  lin_tick_cnt #(.LIMIT(RST_HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .clr(hold_set || vcc_uv || !hold_act),
    .run(tick_us && hold_act && !vcc_uv),
    .done(hold_done)
  );

  lin_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick_us),
    .sup_ok(sup_ok), .sup_low(sup_low),
    .en_s(en_s), .en_fall(en_fall), .txd_s(txd_s),
    .uv_trip(uv_trip), .hold_done(hold_done),
    .bus_wake(bus_wake), .prewake(prewake),
    .mode(mode), .hold_act(hold_act), .hold_set(hold_set),
    .wake_flag(wake_flag), .pw_seen(pw_seen), .sel_pend(sel_pend)
  );

  assign reg_en        = mode_reg_on(mode);
  assign tx_en         = (mode == M_NORMAL) && !sel_pend;
  assign rx_en         = (mode == M_NORMAL);
  assign nres_o        = reg_en && !hold_act;
  assign term_full     = (mode == M_FAILSAFE) || (mode == M_NORMAL) ||
                         (mode_low_power(mode) && pw_seen);
  assign rxd_force_low = (mode == M_SLEEP) || ((mode == M_FAILSAFE) && wake_flag);
endmodule

// File: rtl/lin_mode_chk.sv
module lin_mode_chk (
  input logic clk,
  input logic rst_n,
  input logic sup_low,
  input logic vcc_uv,
  input logic bus_wake,
  input logic reg_en,
  input logic tx_en,
  input logic rx_en,
  input logic nres_o,
  input logic term_full,
  input logic rxd_force_low
);
  // R3
  tx_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> (reg_en && nres_o && term_full && rx_en));

  // R10
  brownout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_low |=> (!reg_en && !nres_o && !tx_en));

  // R9
  uv_reset_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nres_o) && reg_en && $past(reg_en)) |-> $past(vcc_uv));

  // R7
  wake_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rxd_force_low) && reg_en) |-> $past(bus_wake));

  // R6
  weak_pullup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!term_full && reg_en) |-> (!tx_en && !rx_en && nres_o));
endmodule

bind lin_mode_ctrl lin_mode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sup_low(sup_low), .vcc_uv(vcc_uv),
  .bus_wake(bus_wake), .reg_en(reg_en), .tx_en(tx_en), .rx_en(rx_en),
  .nres_o(nres_o), .term_full(term_full), .rxd_force_low(rxd_force_low)
);

// File: tb/sim_lin_mode_ctrl.sv
module sim_lin_mode_ctrl;
  localparam int HOLD = 20;
  localparam int DEB  = 3;

  // Pattern {reg_en, tx_en, rx_en, nres_o, term_full, rxd_force_low}
  localparam logic [5:0] P_UNP   = 6'b000000;
  localparam logic [5:0] P_FSH   = 6'b100010;
  localparam logic [5:0] P_FSR   = 6'b100110;
  localparam logic [5:0] P_NRM   = 6'b111110;
  localparam logic [5:0] P_SIL   = 6'b100100;
  localparam logic [5:0] P_SILPW = 6'b100110;
  localparam logic [5:0] P_SLP   = 6'b000001;
  localparam logic [5:0] P_SLPPW = 6'b000011;
  localparam logic [5:0] P_FSWH  = 6'b100011;
  localparam logic [5:0] P_FSWR  = 6'b100111;

  logic clk = 1'b0, rst_n = 1'b0, tick_us = 1'b0;
  logic sup_ok = 1'b0, sup_low = 1'b0, vcc_uv = 1'b0;
  logic bus_wake = 1'b0, prewake = 1'b0, en_pin = 1'b0, txd_pin = 1'b1;
  logic reg_en, tx_en, rx_en, nres_o, term_full, rxd_force_low;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  lin_mode_ctrl #(.RST_HOLD(HOLD), .UV_DEB(DEB)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .sup_ok(sup_ok),
    .sup_low(sup_low), .vcc_uv(vcc_uv), .bus_wake(bus_wake),
    .prewake(prewake), .en_pin(en_pin), .txd_pin(txd_pin),
    .reg_en(reg_en), .tx_en(tx_en), .rx_en(rx_en), .nres_o(nres_o),
    .term_full(term_full), .rxd_force_low(rxd_force_low)
  );

  always #10 clk = ~clk;

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      tick_us = (k == 3);
      k = (k + 1) % 4;
    end
  end

  task automatic chk(string req, logic [5:0] exp);
    logic [5:0] act;
    act = {reg_en, tx_en, rx_en, nres_o, term_full, rxd_force_low};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    clks(3);
    chk("R1 in reset", P_UNP);
    rst_n = 1'b1;
    clks(2);
    chk("R1 unpowered", P_UNP);
  endtask

  task automatic t_power_up;
    sup_ok = 1'b1;
    clks(2);
    chk("R1 failsafe entry", P_FSH);
    en_pin = 1'b1;
    clks(4 * (HOLD - 3));
    chk("R2 hold ignores EN", P_FSH);
    clks(4 * 6);
    chk("R3 normal after hold", P_NRM);
  endtask

  task automatic t_undervoltage;
    vcc_uv = 1'b1;
    clks(3);
    vcc_uv = 1'b0;
    clks(2);
    chk("R9 short glitch ignored", P_NRM);
    vcc_uv = 1'b1;
    clks(4 * (DEB + 2));
    chk("R9 debounced trip", P_FSH);
    clks(4 * (HOLD + 2));
    chk("R2 hold frozen while uv", P_FSH);
    vcc_uv = 1'b0;
    clks(4 * (HOLD - 3));
    chk("R2 hold restarted", P_FSH);
    clks(4 * 6);
    chk("R3 normal after uv hold", P_NRM);
  endtask

  task automatic t_silent_wake;
    txd_pin = 1'b1;
    en_pin  = 1'b0;
    clks(12);
    chk("R4 silent selected", P_SIL);
    prewake = 1'b1;
    clks(1);
    prewake = 1'b0;
    clks(1);
    chk("R6 silent prewake termination", P_SILPW);
    bus_wake = 1'b1;
    clks(1);
    chk("R7 wake from silent", P_FSWR);
    bus_wake = 1'b0;
    en_pin = 1'b1;
    clks(6);
    chk("R7 normal after wake", P_NRM);
  endtask

  task automatic t_silent_en;
    en_pin = 1'b0;
    clks(12);
    chk("R4 silent again", P_SIL);
    en_pin = 1'b1;
    clks(6);
    chk("R7 silent to normal direct", P_NRM);
  endtask

  task automatic t_sleep_wake;
    en_pin = 1'b0;
    clks(1);
    txd_pin = 1'b0;
    clks(12);
    chk("R5 sleep with late txd fall", P_SLP);
    prewake = 1'b1;
    clks(1);
    chk("R6 sleep prewake termination", P_SLPPW);
    prewake = 1'b0;
    txd_pin = 1'b1;
    bus_wake = 1'b1;
    clks(1);
    chk("R8 wake from sleep", P_FSWH);
    bus_wake = 1'b0;
    clks(4 * (HOLD + 3));
    chk("R8 hold ends, wake kept", P_FSWR);
    en_pin = 1'b1;
    clks(6);
    chk("R3 normal clears wake", P_NRM);
  endtask

  task automatic t_sleep_en;
    en_pin  = 1'b0;
    txd_pin = 1'b0;
    clks(12);
    chk("R5 sleep selected", P_SLP);
    txd_pin = 1'b1;
    en_pin  = 1'b1;
    clks(6);
    chk("R11 sleep to failsafe via EN", P_FSH);
    clks(4 * (HOLD + 3));
    chk("R11 normal after hold", P_NRM);
  endtask

  task automatic t_supply;
    sup_low = 1'b1;
    clks(1);
    chk("R10 brownout from normal", P_UNP);
    sup_low = 1'b0;
    clks(2);
    chk("R10 repower to failsafe", P_FSH);
    clks(4 * (HOLD + 3));
    chk("R10 normal after repower", P_NRM);
    en_pin  = 1'b0;
    txd_pin = 1'b0;
    clks(12);
    chk("R5 sleep before loss", P_SLP);
    sup_ok = 1'b0;
    clks(1);
    chk("R10 supply loss from sleep", P_UNP);
    txd_pin = 1'b1;
    sup_ok  = 1'b1;
    clks(2);
    chk("R10 repower lands failsafe", P_FSH);
    clks(4 * (HOLD + 3));
    chk("R2 hold done, EN low", P_FSR);
  endtask

  initial begin
    t_reset();
    t_power_up();
    t_undervoltage();
    t_silent_wake();
    t_silent_en();
    t_sleep_wake();
    t_sleep_en();
    t_supply();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule